// File: doc/BRIEF.md
# Multiphase Square-Wave Ring

This block produces a set of equal-frequency square waves whose phases are evenly spaced. Internally it is a circular register of `TAPS` bits. Each bit drives one output pin. A synchronous reset loads a contiguous run of ones into the low half of the register and zeros into the rest.

After reset, each cycle in which the step enable is high rotates the whole ring by one position. Each output therefore repeats every `TAPS` enabled steps, and output k+1 replays output k one step later. The enable stands in for a shift tick made somewhere else in the same clock domain. How often it pulses sets the output frequency, which is the tick rate divided by `TAPS`. Once started, the ring runs with no further intervention.

Top module: `multiphase_gen`

## Requirements
- R1: A clock edge with `rst_n` low loads the ring so that `phase_out[k]` is 1 for k < floor(TAPS/2) and 0 for all higher k.
- R2: A clock edge with `rst_n` high and `step_en` high makes `phase_out[k]` equal the previous `phase_out[k-1]` for k >= 1, and makes `phase_out[0]` equal the previous `phase_out[TAPS-1]`.
- R3: A clock edge with `rst_n` high and `step_en` low leaves `phase_out` unchanged.
- R4: Starting from the reset pattern, `phase_out` returns to that pattern after exactly `TAPS` enabled steps and differs from it after every smaller nonzero number of steps.
- R5: Each output is high in exactly floor(TAPS/2) of any `TAPS` consecutive enabled steps. For odd `TAPS` this gives a duty of (TAPS-1)/(2*TAPS). The number of high outputs stays at floor(TAPS/2) at all times after reset.
- R6: Reset takes priority over the enable: an edge with `rst_n` low and `step_en` high still loads the R1 pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; reloads the half-ones pattern |
| step_en | input | 1 | One-cycle shift tick; rotates the ring by one position when high |
| phase_out | output | TAPS | One square wave per bit; bit k+1 lags bit k by one step |

## Verification
Every result is due one clock after the edge that samples its stimulus. This holds for the reset load, for a rotation and for a hold. The bench drives `rst_n` and `step_en` on the falling edge and compares the outputs on the next falling edge against a model that it advances by one step for each edge. Period, duty and lag are counted in enabled steps rather than clock cycles, so random gaps in the enable do not shift any expected value. The bench runs an even-width and an odd-width instance side by side, which covers both duty cases.

// File: rtl/mpg_pkg.sv
// Package: mpg_pkg
// Shared helpers for the multiphase ring. It holds the rule that sets how
// many bits of the ring start high.
package mpg_pkg;

    // Number of ones preloaded into a ring of the given width (floor of half).
    function automatic int unsigned ones_for(input int unsigned taps);
        return taps / 2;
    endfunction

endpackage

// File: rtl/mpg_seed.sv
// Module: mpg_seed
// Builds the constant start pattern of the ring: ones in the lowest
// floor(TAPS/2) positions and zeros above. Purely combinational and constant
// for a given TAPS. Assumes TAPS >= 2.
module mpg_seed #(
    parameter int unsigned TAPS = 10
) (
    output logic [TAPS-1:0] seed
);
    import mpg_pkg::*;

    localparam int unsigned ONES = ones_for(TAPS);

    // One constant driver per position: high below the run boundary.
    for (genvar i = 0; i < TAPS; i++) begin : g_seed
        assign seed[i] = (i < ONES) ? 1'b1 : 1'b0;
    end

endmodule

// File: rtl/mpg_cell.sv
// Module: mpg_cell
// One stage of the ring. A synchronous active-low reset loads its seed bit.
// A high enable copies the upstream stage. A low enable holds the value.
// Assumes all stages share clk, rst_n and en.
module mpg_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic seed_bit,
    input  logic prev_bit,
    output logic q
);

    // Stage register: reset first, then shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= seed_bit;
        end else if (en) begin
            q <= prev_bit;
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> $stable(q));

endmodule

// File: rtl/multiphase_gen.sv
// Module: multiphase_gen
// A TAPS-bit circular register whose bits are evenly phased square waves.
// On reset the low half is loaded with ones. Each enabled cycle then moves
// every bit one place toward higher indices, and the top bit wraps to bit 0.
// Assumes step_en is a single-cycle tick in the clk domain and TAPS >= 2.
module multiphase_gen #(
    parameter int unsigned TAPS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    output logic [TAPS-1:0] phase_out
);
    import mpg_pkg::*;

    localparam int unsigned ONES = ones_for(TAPS);

    logic [TAPS-1:0] seed_vec;
    logic [TAPS-1:0] ring_q;

    // Constant start pattern.
    mpg_seed #(.TAPS(TAPS)) u_seed (
        .seed (seed_vec)
    );

    // Ring of stages; stage 0 takes its input from the top stage.
    for (genvar k = 0; k < TAPS; k++) begin : g_ring
        if (k == 0) begin : g_wrap
            mpg_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (step_en),
                .seed_bit (seed_vec[0]),
                .prev_bit (ring_q[TAPS-1]),
                .q        (ring_q[0])
            );
        end else begin : g_link
            mpg_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (step_en),
                .seed_bit (seed_vec[k]),
                .prev_bit (ring_q[k-1]),
                .q        (ring_q[k])
            );
        end
    end

    assign phase_out = ring_q;

    // R1 R6
    reset_load_chk: assert property (@(posedge clk)
        (!rst_n) |=> (phase_out == seed_vec));

    // R2
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en) |=>
            (phase_out == {$past(phase_out[TAPS-2:0]), $past(phase_out[TAPS-1])}));

    // R5
    ones_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_out) == ONES);

endmodule

// File: tb/test_multiphase_gen.sv
// Bench for multiphase_gen: an even instance (10 taps) and an odd instance
// (7 taps) run side by side, compared against a bench-side model.
module test_multiphase_gen;

    localparam int unsigned WA = 10;
    localparam int unsigned WB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_a = 1'b0;
    logic          en_b = 1'b0;
    logic [WA-1:0] out_a;
    logic [WB-1:0] out_b;

    logic [15:0]   mdl_a;
    logic [15:0]   mdl_b;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    multiphase_gen #(.TAPS(WA)) i_multiphase_gen (
        .clk (clk), .rst_n (rst_n), .step_en (en_a), .phase_out (out_a)
    );

    multiphase_gen #(.TAPS(WB)) i_multiphase_gen_odd (
        .clk (clk), .rst_n (rst_n), .step_en (en_b), .phase_out (out_b)
    );

    function automatic logic [15:0] mask_of(input int w);
        return (16'h1 << w) - 16'h1;
    endfunction

    function automatic logic [15:0] seed_of(input int w);
        return (16'h1 << (w / 2)) - 16'h1;
    endfunction

    function automatic logic [15:0] rot_of(input logic [15:0] v, input int w);
        return ((v << 1) | (v >> (w - 1))) & mask_of(w);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge act, sample on the next falling edge.
    task automatic step(input logic r, input logic ea, input logic eb);
        rst_n = r; en_a = ea; en_b = eb;
        @(posedge clk);
        if (!r) begin
            mdl_a = seed_of(WA);
            mdl_b = seed_of(WB);
        end else begin
            if (ea) mdl_a = rot_of(mdl_a, WA);
            if (eb) mdl_b = rot_of(mdl_b, WB);
        end
        @(negedge clk);
    endtask

    task automatic cmp_both(input string tag);
        chk({6'd0, out_a}, mdl_a, tag);
        chk({9'd0, out_b}, mdl_b, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] prev_a;
        logic [15:0] prev_b;
        int hi_a [WA];
        int hi_b [WB];
        void'($urandom(32'd2024));
        mdl_a = '0;
        mdl_b = '0;
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R1: reset pattern, low half high
        chk({6'd0, out_a}, 16'h001F, "R1 even");
        chk({9'd0, out_b}, 16'h0007, "R1 odd");

        // R3: idle cycles keep the pattern
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, 1'b0);
            cmp_both("R3 idle hold");
        end

        // R2: single step, explicit lag check output k+1 after == output k before
        prev_a = {6'd0, out_a};
        prev_b = {9'd0, out_b};
        step(1'b1, 1'b1, 1'b1);
        chk({6'd0, out_a[WA-1:1]}, {7'd0, prev_a[WA-2:0]}, "R2 lag even");
        chk({15'd0, out_a[0]}, {15'd0, prev_a[WA-1]}, "R2 wrap even");
        chk({10'd0, out_b[WB-1:1]}, {10'd0, prev_b[WB-2:0]}, "R2 lag odd");
        chk({15'd0, out_b[0]}, {15'd0, prev_b[WB-1]}, "R2 wrap odd");

        // R6: reset with enable high still loads the seed
        step(1'b0, 1'b1, 1'b1);
        chk({6'd0, out_a}, 16'h001F, "R6 even");
        chk({9'd0, out_b}, 16'h0007, "R6 odd");

        // R4 R5: period and duty over a full revolution of the even ring
        for (int k = 0; k < WA; k++) hi_a[k] = 0;
        for (int k = 0; k < WB; k++) hi_b[k] = 0;
        for (int s = 1; s <= WA; s++) begin
            step(1'b1, 1'b1, 1'b0);
            for (int k = 0; k < WA; k++) hi_a[k] += int'(out_a[k]);
            if (s < WA) begin
                n_checks++;
                if (out_a == WA'(16'h001F)) begin
                    n_errors++;
                    $display("FAIL R4 even early repeat at step %0d actual=%h expected=not %h",
                             s, out_a, 16'h001F);
                end
            end
        end
        chk({6'd0, out_a}, 16'h001F, "R4 even period");
        for (int k = 0; k < WA; k++) chk(16'(hi_a[k]), 16'(WA / 2), "R5 even duty");

        // R4 R5: same for the odd ring, with idle gaps between the steps
        for (int s = 1; s <= WB; s++) begin
            step(1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b1);
            for (int k = 0; k < WB; k++) hi_b[k] += int'(out_b[k]);
            if (s < WB) begin
                n_checks++;
                if (out_b == WB'(16'h0007)) begin
                    n_errors++;
                    $display("FAIL R4 odd early repeat at step %0d actual=%h expected=not %h",
                             s, out_b, 16'h0007);
                end
            end
        end
        chk({9'd0, out_b}, 16'h0007, "R4 odd period");
        for (int k = 0; k < WB; k++) chk(16'(hi_b[k]), 16'(WB / 2), "R5 odd duty");

        // R2 R3 R5: random enables with rare resets, compared against the model
        for (int i = 0; i < 600; i++) begin
            logic r;
            r = ($urandom % 50) != 0;
            step(r, 1'($urandom % 2), 1'($urandom % 2));
            cmp_both("R2 R3 random");
            chk(16'($countones(out_a)), 16'(WA / 2), "R5 even count");
            chk(16'($countones(out_b)), 16'(WB / 2), "R5 odd count");
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule